// File: doc/BRIEF.md
# Serial receiver with per-character error tagging

This block turns an asynchronous serial input line into characters. A sample tick paces it; the number of ticks per bit is a parameter. The word length and the parity mode come from static configuration inputs. Each finished character goes into a receive queue of 16 entries. Each entry carries the character and three error tags: parity, framing and break. The tags travel with the entry, so the consumer always sees the errors that belong to the character it is about to take.

The consumer reads the head of the queue on the read port and pops it with a one-cycle strobe. A status-read strobe clears the sticky flags. These are overrun, and an aggregate flag that says an errored character has been in the queue. The aggregate flag clears only when no errored entries remain. A queue-clear strobe throws away all stored characters. It does not disturb a character that is still being shifted in.

Top module: `uart_rx_tag`

## Requirements
- R1: `word_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Bits arrive least significant first, each sampled at mid-bit. The character appears right-aligned on `rd_data`, with the unused upper bits zero.
- R2: When `par_en` is 1, one parity bit follows the data. The expected value depends on the parity mode:
  - `par_stick`=0 with `par_even`=1: the XOR of the data bits.
  - `par_stick`=0 with `par_even`=0: the inverse of that XOR.
  - `par_stick`=1: the inverse of `par_even`.
  A received parity bit that differs from the expected value sets the entry's parity tag (`rd_pe`). With `par_en`=0 the tag is 0.
- R3: A stop bit sampled low sets the entry's framing tag (`rd_fe`).
- R4: A line held low through the whole frame gives one entry with data 0 and both `rd_brk` and `rd_fe` set. The frame is the start bit, the data bits, any parity bit and the stop bit. After any low stop bit, the receiver waits for the line to go high before it looks for a new start bit.
- R5: The queue is first-in first-out. `rd_data`, `rd_pe`, `rd_fe` and `rd_brk` always show the head entry and are all 0 when the queue is empty. A pulse on `rd_pop` moves to the next entry.
- R6: `fifo_count` gives the number of stored entries. `data_ready` is 1 exactly while that number is non-zero.
- R7: A character that finishes while the queue holds 16 entries is discarded and sets `overrun`. A `stat_rd` pulse clears `overrun`.
- R8: `err_any` becomes 1 once an entry with any error tag is stored. A `stat_rd` pulse clears it only when no errored entry remains in the queue; while one remains, it stays 1.
- R9: A `fifo_clr` pulse empties the queue, so the count becomes 0 on the next cycle. A character that is being received at that moment is still stored when it finishes.
- R10: A low level on the line that is high again at the middle of the start bit is ignored, and no entry is stored.
- R11: After reset, the count is 0 and `data_ready`, `overrun`, `err_any` and the head tags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling tick; one bit lasts OSR ticks |
| rxd | input | 1 | Serial input line, idle high |
| word_len | input | 2 | Data bit count code (5 + code) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Stick parity select |
| rd_pop | input | 1 | Pop the head entry |
| stat_rd | input | 1 | Status read strobe; clears sticky flags |
| fifo_clr | input | 1 | Empty the queue |
| rd_data | output | 8 | Head character |
| rd_pe | output | 1 | Head parity tag |
| rd_fe | output | 1 | Head framing tag |
| rd_brk | output | 1 | Head break tag |
| data_ready | output | 1 | Queue not empty |
| overrun | output | 1 | Sticky overrun flag |
| err_any | output | 1 | Sticky aggregate error flag |
| fifo_count | output | 5 | Stored entry count |

## Verification
The assertions assume the following about the inputs:
- The configuration inputs stay constant while a frame is in flight.
- `tick` comes at a steady rate.
- Each bit on the line lasts OSR ticks.

The bench changes the configuration only between frames. It gives `tick` a fixed period of two clocks. It holds every line bit for exactly 2·OSR clocks, so each mid-bit sample lands well inside its bit. Break and framing cases return the line high before the next frame, as the receiver expects.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [CHAR_W-1:0] data;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITH
  } rx_state_e;
endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic [1:0]        word_len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  output logic              rx_valid,
  output rx_entry_t         rx_char
);
  localparam int CW   = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int HALF = OSR / 2;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [2:0]        bit_idx;
  logic [CHAR_W-1:0] shreg;
  logic              par_acc;
  logic              par_bit;
  logic              all_low;
  logic [2:0]        last_idx;
  logic              par_exp;
  logic              bit_end;

  assign last_idx = 3'd4 + {1'b0, word_len};
  assign bit_end  = (cnt == CW'(OSR - 1));
  assign par_exp  = par_stick ? ~par_even : (par_even ? par_acc : ~par_acc);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      par_bit  <= 1'b0;
      all_low  <= 1'b0;
      rx_valid <= 1'b0;
      rx_char  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (state)
          S_IDLE: begin
            if (!rxd) begin
              state   <= S_START;
              cnt     <= '0;
              all_low <= 1'b1;
            end
          end
          S_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (rxd) begin
                state <= S_IDLE;
              end else begin
                state   <= S_DATA;
                bit_idx <= '0;
                shreg   <= '0;
                par_acc <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (bit_end) begin
              cnt            <= '0;
              shreg[bit_idx] <= rxd;
              par_acc        <= par_acc ^ rxd;
              all_low        <= all_low & ~rxd;
              if (bit_idx == last_idx) begin
                state <= par_en ? S_PAR : S_STOP;
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_PAR: begin
            if (bit_end) begin
              cnt     <= '0;
              par_bit <= rxd;
              all_low <= all_low & ~rxd;
              state   <= S_STOP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (bit_end) begin
              cnt          <= '0;
              rx_valid     <= 1'b1;
              rx_char.data <= shreg;
              rx_char.pe   <= par_en & (par_bit != par_exp);
              rx_char.fe   <= ~rxd;
              rx_char.brk  <= all_low & ~rxd;
              state        <= rxd ? S_IDLE : S_WAITH;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_WAITH: begin
            if (rxd) state <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R1: a finished character is reported for a single cycle
  a_r1_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R4: a break always carries a framing error and an all-zero character
  a_r4_brk_has_fe: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_char.brk) |-> (rx_char.fe && rx_char.data == '0));
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_req,
  input  rx_entry_t       wr_entry,
  input  logic            rd_req,
  input  logic            clr,
  output rx_entry_t       head,
  output logic [CNTW-1:0] count,
  output logic            wr_ok,
  output logic            rd_ok,
  output logic            drop
);
  rx_entry_t       mem [DEPTH];
  logic [AW-1:0]   wptr;
  logic [AW-1:0]   rptr;
  logic            full;
  logic            empty;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);
  assign wr_ok = wr_req & ~full & ~clr;
  assign rd_ok = rd_req & ~empty & ~clr;
  assign drop  = wr_req & full & ~clr;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_ok) wptr <= next_ptr(wptr);
      if (rd_ok) rptr <= next_ptr(rptr);
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = empty ? '0 : mem[rptr];

  // R9: a clear leaves the queue empty on the next cycle
  a_r9_clr_empties: assert property (@(posedge clk) disable iff (rst)
    clr |=> (count == '0));

  // R7: a write into a full queue does not change the occupancy
  a_r7_full_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_req && !clr) |=> (count == CNTW'(DEPTH)));
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int CNTW = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic push_ok,
  input  logic push_err,
  input  logic pop_ok,
  input  logic pop_err,
  input  logic clr,
  input  logic drop,
  input  logic stat_rd,
  output logic overrun,
  output logic err_any
);
  logic [CNTW-1:0] err_cnt;
  logic [CNTW-1:0] err_cnt_nx;

  always_comb begin
    err_cnt_nx = err_cnt;
    if (clr) begin
      err_cnt_nx = '0;
    end else begin
      if (push_ok && push_err) err_cnt_nx = err_cnt_nx + 1'b1;
      if (pop_ok && pop_err)   err_cnt_nx = err_cnt_nx - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_cnt <= '0;
      err_any <= 1'b0;
      overrun <= 1'b0;
    end else begin
      err_cnt <= err_cnt_nx;
      if (err_cnt_nx != '0) err_any <= 1'b1;
      else if (stat_rd)     err_any <= 1'b0;
      if (drop)             overrun <= 1'b1;
      else if (stat_rd)     overrun <= 1'b0;
    end
  end

  // R7: a discarded character always leaves overrun set
  a_r7_ovr_set: assert property (@(posedge clk) disable iff (rst)
    drop |=> overrun);

  // R8: the aggregate flag is up whenever an errored entry is stored
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    (err_cnt != '0) |-> err_any);
endmodule

// File: rtl/uart_rx_tag.sv
module uart_rx_tag
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rxd,
  input  logic [1:0]      word_len,
  input  logic            par_en,
  input  logic            par_even,
  input  logic            par_stick,
  input  logic            rd_pop,
  input  logic            stat_rd,
  input  logic            fifo_clr,
  output logic [7:0]      rd_data,
  output logic            rd_pe,
  output logic            rd_fe,
  output logic            rd_brk,
  output logic            data_ready,
  output logic            overrun,
  output logic            err_any,
  output logic [CNTW-1:0] fifo_count
);
  logic      rx_valid;
  rx_entry_t rx_char;
  rx_entry_t head;
  logic      wr_ok;
  logic      rd_ok;
  logic      drop;

  uart_rx_deser #(.OSR(OSR)) u_deser (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .rxd       (rxd),
    .word_len  (word_len),
    .par_en    (par_en),
    .par_even  (par_even),
    .par_stick (par_stick),
    .rx_valid  (rx_valid),
    .rx_char   (rx_char)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .CNTW(CNTW)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_req   (rx_valid),
    .wr_entry (rx_char),
    .rd_req   (rd_pop),
    .clr      (fifo_clr),
    .head     (head),
    .count    (fifo_count),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .drop     (drop)
  );

  uart_rx_status #(.CNTW(CNTW)) u_status (
    .clk      (clk),
    .rst      (rst),
    .push_ok  (wr_ok),
    .push_err (rx_char.pe | rx_char.fe | rx_char.brk),
    .pop_ok   (rd_ok),
    .pop_err  (head.pe | head.fe | head.brk),
    .clr      (fifo_clr),
    .drop     (drop),
    .stat_rd  (stat_rd),
    .overrun  (overrun),
    .err_any  (err_any)
  );

  assign rd_data    = head.data;
  assign rd_pe      = head.pe;
  assign rd_fe      = head.fe;
  assign rd_brk     = head.brk;
  assign data_ready = (fifo_count != '0);

  // R5: an empty queue shows no error tags on the read port
  a_r5_empty_clean: assert property (@(posedge clk) disable iff (rst)
    (fifo_count == '0) |-> !(rd_pe || rd_fe || rd_brk));
endmodule

// File: tb/uart_rx_tag_bench.sv
module uart_rx_tag_bench;
  localparam int OSR  = 16;
  localparam int BITC = OSR * 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic       rd_pop = 1'b0, stat_rd = 1'b0, fifo_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_pe, rd_fe, rd_brk, data_ready, overrun, err_any;
  logic [4:0] fifo_count;

  int n_chk = 0;
  int n_bad = 0;

  uart_rx_tag #(.OSR(OSR), .DEPTH(16)) u_uart_rx_tag (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .word_len(word_len),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .rd_pop(rd_pop), .stat_rd(stat_rd), .fifo_clr(fifo_clr),
    .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk),
    .data_ready(data_ready), .overrun(overrun), .err_any(err_any),
    .fifo_count(fifo_count)
  );

  always #5 clk = ~clk;
  always @(posedge clk) tick <= ~tick;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic calc_par(input logic [7:0] d, input int nb,
                                    input logic ev, input logic st);
    logic x = 1'b0;
    for (int i = 0; i < nb; i++) x ^= d[i];
    if (st) return ~ev;
    return ev ? x : ~x;
  endfunction

  task automatic line_bit(input logic b);
    @(negedge clk) rxd = b;
    repeat (BITC - 1) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input logic pen,
                            input logic pbit, input logic stopb);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (pen) line_bit(pbit);
    line_bit(stopb);
    line_bit(1'b1);
  endtask

  task automatic set_cfg(input int nb, input logic pe, input logic ev, input logic st);
    @(negedge clk);
    word_len = 2'(nb - 5); par_en = pe; par_even = ev; par_stick = st;
  endtask

  task automatic pulse_pop();
    @(negedge clk) rd_pop = 1'b1;
    @(negedge clk) rd_pop = 1'b0;
  endtask

  task automatic pulse_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
  endtask

  task automatic pop_expect(input string tag, input logic [7:0] d, input logic pe,
                            input logic fe, input logic brk);
    @(negedge clk);
    check({tag, " data"}, rd_data, d);
    check({tag, " pe"}, rd_pe, pe);
    check({tag, " fe"}, rd_fe, fe);
    check({tag, " brk"}, rd_brk, brk);
    pulse_pop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", n_chk, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int nb;
    logic pe, ev, st, bad, pb;
    process::self().srandom(32'h5eed_1234);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 count", fifo_count, 0);
    check("R11 ready", data_ready, 0);
    check("R11 overrun", overrun, 0);
    check("R11 err_any", err_any, 0);
    check("R11 tags", {rd_pe, rd_fe, rd_brk}, 0);

    // R1 / R6 basic 8N1
    send_frame(8'hA5, 8, 0, 0, 1);
    check("R6 ready after char", data_ready, 1);
    check("R6 count one", fifo_count, 1);
    pop_expect("R1 8bit", 8'hA5, 0, 0, 0);
    @(negedge clk);
    check("R6 ready cleared", data_ready, 0);

    // R1 short word lengths
    for (int w = 5; w < 8; w++) begin
      set_cfg(w, 0, 0, 0);
      send_frame(8'hFF, w, 0, 0, 1);
      pop_expect("R1 short word", 8'((1 << w) - 1), 0, 0, 0);
    end

    // R2 parity modes, good and bad
    for (int m = 0; m < 4; m++) begin
      ev = m[0]; st = m[1];
      set_cfg(7, 1, ev, st);
      pb = calc_par(8'h35, 7, ev, st);
      send_frame(8'h35, 7, 1, pb, 1);
      pop_expect("R2 good parity", 8'h35, 0, 0, 0);
      send_frame(8'h35, 7, 1, ~pb, 1);
      pop_expect("R2 bad parity", 8'h35, 1, 0, 0);
    end
    pulse_stat();

    // R3 framing error, R8 sticky until status read
    set_cfg(8, 0, 0, 0);
    send_frame(8'h55, 8, 0, 0, 0);
    send_frame(8'h0F, 8, 0, 0, 1);
    check("R8 err_any set", err_any, 1);
    pulse_stat();
    check("R8 held while errored entry stored", err_any, 1);
    pop_expect("R3 framing", 8'h55, 0, 1, 0);
    check("R8 sticky after pop", err_any, 1);
    pop_expect("R5 next head", 8'h0F, 0, 0, 0);
    pulse_stat();
    check("R8 cleared by status read", err_any, 0);

    // R4 break
    @(negedge clk) rxd = 1'b0;
    repeat (BITC * 15) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC * 2) @(negedge clk);
    check("R4 one entry", fifo_count, 1);
    pop_expect("R4 break", 8'h00, 0, 1, 1);
    pulse_stat();

    // R10 start glitch
    @(negedge clk) rxd = 1'b0;
    repeat (6) @(negedge clk);
    rxd = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    check("R10 glitch ignored", fifo_count, 0);

    // R7 overrun
    for (int i = 0; i < 17; i++) send_frame(8'(i + 8'h40), 8, 0, 0, 1);
    check("R7 count full", fifo_count, 16);
    check("R7 overrun set", overrun, 1);
    pulse_stat();
    check("R7 overrun cleared", overrun, 0);
    for (int i = 0; i < 16; i++) pop_expect("R7 order kept", 8'(i + 8'h40), 0, 0, 0);
    check("R7 dropped char absent", fifo_count, 0);

    // R9 clear during a frame
    send_frame(8'h11, 8, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 1);
    fork
      send_frame(8'h3C, 8, 0, 0, 1);
      begin
        repeat (BITC * 3) @(negedge clk);
        fifo_clr = 1'b1;
        @(negedge clk) fifo_clr = 1'b0;
        check("R9 emptied", fifo_count, 0);
      end
    join
    check("R9 in-flight kept", fifo_count, 1);
    pop_expect("R9 in-flight data", 8'h3C, 0, 0, 0);

    // random frames
    for (int k = 0; k < 40; k++) begin
      nb = 5 + int'($urandom_range(3));
      pe = 1'($urandom); ev = 1'($urandom); st = 1'($urandom);
      bad = pe & ($urandom_range(3) == 0);
      d = 8'($urandom) & 8'((1 << nb) - 1);
      set_cfg(nb, pe, ev, st);
      pb = calc_par(d, nb, ev, st) ^ bad;
      send_frame(d, nb, pe, pb, 1);
      pop_expect("R1 R2 random", d, bad, 0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule